// File: doc/BRIEF.md
# Collision-Backoff Slot Controller

This block paces retransmissions on a shared serial line where stations sense the carrier and detect collisions. It divides time into slots measured in bit periods and decides when the local transmitter may start. The bit period comes from an external bit-rate tick. The slot length in bit periods comes from a programmable value.

Two backoff styles are selectable. In random mode the block counts collisions for the current frame. After each collision it skips a pseudo-random number of slots, with a window that doubles per collision and stops growing after eight. After sixteen collisions it gives up and raises an abort flag. Software writes the count register to zero to mark a new frame. The count therefore survives retransmits of the same frame. In fixed mode the same register holds the length of a repeating slot cycle. The station may transmit only during its own assigned slot within that cycle.

Top module: `csma_backoff_ctrl`

## Requirements
- R1: A slot lasts `slot_len` bit ticks, and a value of 0 means 256 ticks. The slot position advances only on clock edges that sample `bit_tick` high. Slot boundaries fall on every `slot_len`-th tick counted from reset.
- R2: `tx_ok` is a register. It goes from 0 to 1 only on the edge that samples the final tick of a slot. In random mode, with `tx_req` high and no pending backoff, it rises at the first boundary.
- R3: When `tx_req` is sampled low, `tx_ok` is low after that edge.
- R4: In random mode (`det_mode` = 0), a sampled `collision` raises `coll_cnt` by one, saturating at 255, and clears `tx_ok` on the same edge. The count is kept across retransmissions.
- R5: A sampled `cnt_wr` loads `coll_cnt` with `cnt_wdata` on that edge. It takes priority over a simultaneous collision. Writing 0 clears the count.
- R6: In random mode, after a collision that brings the count to n, the block skips k slot boundaries, with 0 <= k <= 2^min(n,8) - 1. It raises `tx_ok` on the (k+1)-th boundary after the collision edge. The value of k comes from a free-running 16-bit LFSR.
- R7: In random mode, `abort` is 1 while `coll_cnt` >= 16. While it is 1, `tx_ok` stays low. Writing a value below 16 releases it, and the pending backoff then resumes.
- R8: In fixed mode (`det_mode` = 1), `coll_cnt` holds a cycle length M. The slot index is 0 after reset, steps at each boundary, and wraps to 0 after M-1. While `tx_req` is held, `tx_ok` is 1 from the boundary that enters index `my_slot` until the next boundary. Collisions leave `coll_cnt` unchanged.
- R9: In fixed mode a collision clears `tx_ok` on the sampling edge. Transmission is next permitted at the station's next own slot.
- R10: Reset (synchronous, active high) clears `tx_ok`, `coll_cnt`, `abort`, the slot position and the slot index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| collision | input | 1 | One-cycle pulse when a collision is seen |
| tx_req | input | 1 | Local transmitter wants the line |
| slot_len | input | 8 | Slot length in bit periods (0 = 256) |
| det_mode | input | 1 | 0 = random backoff, 1 = fixed slot cycle |
| my_slot | input | 8 | Assigned slot index in fixed mode |
| cnt_wr | input | 1 | Software write strobe for the count register |
| cnt_wdata | input | 8 | Value written to the count register |
| tx_ok | output | 1 | Transmission permitted |
| coll_cnt | output | 8 | Collision count (random) or cycle length (fixed) |
| abort | output | 1 | Collision limit reached in random mode |

## Verification
The properties assume several things about the inputs. `det_mode` and `slot_len` change only while reset is asserted. `collision` arrives as single-cycle pulses. A write to the count register happens only when the slot index is already inside the new cycle. The stimulus reconfigures the block only inside its reset sequence, and every collision and write pulse lasts exactly one clock. In fixed mode the cycle length is written just after reset, before the first boundary. The random backoff is not predicted exactly. Instead, each measured rise of `tx_ok` is checked against the slot grid and against the allowed window for the current collision count.

// File: rtl/csma_backoff_pkg.sv
`timescale 1ns/1ps
package csma_backoff_pkg;

    localparam int CNT_W       = 8;
    localparam int LFSR_W      = 16;
    localparam int ABORT_LIMIT = 16;
    localparam int EXP_CAP     = 8;

    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef enum logic {
        BO_RANDOM = 1'b0,
        BO_FIXED  = 1'b1
    } bo_style_e;

    typedef struct packed {
        logic grant;
        cnt_t wait_slots;
    } grant_state_t;

    function automatic cnt_t sat_inc(input cnt_t v);
        return (v == '1) ? v : v + CNT_ONE;
    endfunction

    // Backoff window mask for a collision count n: 2^min(n,EXP_CAP) - 1
    function automatic cnt_t window_mask(input cnt_t n);
        int e;
        e = (int'(n) > EXP_CAP) ? EXP_CAP : int'(n);
        return cnt_t'((1 << e) - 1);
    endfunction

endpackage

// File: rtl/csma_lfsr.sv
`timescale 1ns/1ps
module csma_lfsr #(
    parameter int                 STATE_W = 16,
    parameter int                 OUT_W   = 8,
    parameter logic [STATE_W-1:0] TAPS    = 16'hB400,
    parameter logic [STATE_W-1:0] SEED    = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] rnd
);

    logic [STATE_W-1:0] state;
    logic               feedback;

    assign feedback = ^(state & TAPS);
    assign rnd      = state[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else begin
            state <= {state[STATE_W-2:0], feedback};
        end
    end

endmodule

// File: rtl/csma_slot_timer.sv
`timescale 1ns/1ps
module csma_slot_timer
    import csma_backoff_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  cnt_t slot_len,
    input  cnt_t cycle_len,
    output logic slot_end,
    output cnt_t next_index
);

    cnt_t bit_pos;
    cnt_t slot_index;
    cnt_t bit_last;
    cnt_t index_last;

    always_comb begin
        // a zero length wraps to all ones, giving a full 2^CNT_W span
        bit_last   = slot_len - CNT_ONE;
        index_last = cycle_len - CNT_ONE;
        slot_end   = bit_tick && (bit_pos == bit_last);
        next_index = (slot_index == index_last) ? '0 : slot_index + CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_pos    <= '0;
            slot_index <= '0;
        end else if (bit_tick) begin
            if (slot_end) begin
                bit_pos    <= '0;
                slot_index <= next_index;
            end else begin
                bit_pos <= bit_pos + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/csma_collision_ctr.sv
`timescale 1ns/1ps
module csma_collision_ctr
    import csma_backoff_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  cnt_t      wr_data,
    input  logic      collision,
    input  bo_style_e style,
    output cnt_t      count,
    output logic      abort
);

    localparam cnt_t LIMIT = cnt_t'(ABORT_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_en) begin
            count <= wr_data;
        end else if (collision && (style == BO_RANDOM)) begin
            count <= sat_inc(count);
        end
    end

    assign abort = (style == BO_RANDOM) && (count >= LIMIT);

endmodule

// File: rtl/csma_backoff_ctrl.sv
`timescale 1ns/1ps
module csma_backoff_ctrl
    import csma_backoff_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             collision,
    input  logic             tx_req,
    input  logic [CNT_W-1:0] slot_len,
    input  logic             det_mode,
    input  logic [CNT_W-1:0] my_slot,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic             tx_ok,
    output logic [CNT_W-1:0] coll_cnt,
    output logic             abort
);

    bo_style_e    style;
    logic         slot_end;
    cnt_t         next_index;
    cnt_t         rnd;
    grant_state_t cur;
    grant_state_t nxt;

    assign style = bo_style_e'(det_mode);

    csma_slot_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .slot_len   (slot_len),
        .cycle_len  (coll_cnt),
        .slot_end   (slot_end),
        .next_index (next_index)
    );

    csma_lfsr #(
        .STATE_W (LFSR_W),
        .OUT_W   (CNT_W),
        .TAPS    (LFSR_TAPS),
        .SEED    (LFSR_SEED)
    ) u_lfsr (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    csma_collision_ctr u_count (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cnt_wr),
        .wr_data   (cnt_wdata),
        .collision (collision),
        .style     (style),
        .count     (coll_cnt),
        .abort     (abort)
    );

    always_comb begin
        nxt = cur;
        if (collision) begin
            nxt.grant = 1'b0;
            if (style == BO_RANDOM) begin
                nxt.wait_slots = rnd & window_mask(sat_inc(coll_cnt));
            end
        end else if (style == BO_FIXED) begin
            if (slot_end) begin
                nxt.grant = tx_req && (next_index == my_slot);
            end else begin
                nxt.grant = cur.grant && tx_req;
            end
        end else if (abort) begin
            // backoff is frozen while the limit holds
            nxt.grant = 1'b0;
        end else if (cur.grant) begin
            nxt.grant = tx_req;
        end else if (slot_end) begin
            if (cur.wait_slots == '0) begin
                nxt.grant = tx_req;
            end else begin
                nxt.wait_slots = cur.wait_slots - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign tx_ok = cur.grant;

endmodule

// File: rtl/csma_backoff_checker.sv
`timescale 1ns/1ps
module csma_backoff_checker
    import csma_backoff_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bit_tick,
    input logic             collision,
    input logic             tx_req,
    input logic             det_mode,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] coll_cnt,
    input logic             tx_ok,
    input logic             abort,
    input logic             slot_end
);

    assert_tick_gated_R1: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> !$rose(tx_ok));

    assert_rise_on_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_ok) |-> $past(slot_end));

    assert_request_drop_R3: assert property (@(posedge clk) disable iff (rst)
        !tx_req |=> !tx_ok);

    // also covers R9 in fixed mode
    assert_collision_drop_R4: assert property (@(posedge clk) disable iff (rst)
        collision |=> !tx_ok);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        (collision && !det_mode && !cnt_wr && (coll_cnt != '1))
        |=> (coll_cnt == cnt_t'($past(coll_cnt) + CNT_ONE)));

    assert_write_load_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (coll_cnt == $past(cnt_wdata)));

    assert_abort_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        abort |=> !tx_ok);

    assert_fixed_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (det_mode && !cnt_wr) |=> $stable(coll_cnt));

endmodule

bind csma_backoff_ctrl csma_backoff_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .collision (collision),
    .tx_req    (tx_req),
    .det_mode  (det_mode),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .coll_cnt  (coll_cnt),
    .tx_ok     (tx_ok),
    .abort     (abort),
    .slot_end  (slot_end)
);

// File: tb/test_csma_backoff_ctrl.sv
`timescale 1ns/1ps
module test_csma_backoff_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       collision = 1'b0;
    logic       tx_req = 1'b0;
    logic [7:0] slot_len = 8'd4;
    logic       det_mode = 1'b0;
    logic [7:0] my_slot = 8'd0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = 8'd0;
    logic       tx_ok;
    logic [7:0] coll_cnt;
    logic       abort;

    always #2.5 clk = ~clk;

    csma_backoff_ctrl i_csma_backoff_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .collision (collision),
        .tx_req    (tx_req),
        .slot_len  (slot_len),
        .det_mode  (det_mode),
        .my_slot   (my_slot),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .tx_ok     (tx_ok),
        .coll_cnt  (coll_cnt),
        .abort     (abort)
    );

    localparam int K_TX = 0;
    localparam int K_CNT = 1;
    localparam int K_ABORT = 2;

    typedef struct {
        int    at;
        int    kind;
        int    exp;
        string req;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    tick_div = 1;
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // tick for edge cyc+1 is driven at the negedge before it
    always @(negedge clk) bit_tick <= (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);

    function automatic bit tick_at(int e);
        return (tick_div <= 1) || (((e - 1) % tick_div) == 0);
    endfunction

    function automatic int nth_boundary(int r, int len, int n);
        int t;
        t = 0;
        for (int e = r + 1; e < r + 100000; e++) begin
            if (tick_at(e)) begin
                t++;
                if (t == n * len) return e;
            end
        end
        return -1;
    endfunction

    function automatic void check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    function automatic void expect_at(int at, int kind, int exp, string req);
        item_t it;
        it.at = at;
        it.kind = kind;
        it.exp = exp;
        it.req = req;
        sb.push_back(it);
    endfunction

    // monitor: pops expected items as their cycle arrives
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            item_t it;
            it = sb.pop_front();
            if (it.at < cyc) check(it.req, "missed item", it.at, cyc);
            else if (it.kind == K_TX) check(it.req, "tx_ok", int'(tx_ok), it.exp);
            else if (it.kind == K_CNT) check(it.req, "coll_cnt", int'(coll_cnt), it.exp);
            else check(it.req, "abort", int'(abort), it.exp);
        end
    end

    task automatic go_to(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic do_reset(int len, int div, bit det, int slot, bit req, output int r);
        rst = 1'b1;
        collision = 1'b0;
        cnt_wr = 1'b0;
        slot_len = len[7:0];
        tick_div = div;
        det_mode = det;
        my_slot = slot[7:0];
        tx_req = req;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        r = cyc;
    endtask

    task automatic write_count(int v);
        cnt_wr = 1'b1;
        cnt_wdata = v[7:0];
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic wait_grant(int limit, output int e);
        e = -1;
        for (int i = 0; i < limit; i++) begin
            if (tx_ok) begin
                e = cyc;
                break;
            end
            @(negedge clk);
        end
    endtask

    function automatic int window(int n);
        return (1 << ((n > 8) ? 8 : n)) - 1;
    endfunction

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int r;
        int e;
        int b1;
        @(negedge clk);

        // T1: basic grant, release and re-request on the slot grid
        do_reset(5, 1, 1'b0, 0, 1'b1, r);
        expect_at(r + 1, K_TX, 0, "R10");
        expect_at(r + 1, K_CNT, 0, "R10");
        expect_at(r + 1, K_ABORT, 0, "R10");
        expect_at(r + 4, K_TX, 0, "R2");
        expect_at(r + 5, K_TX, 1, "R1");
        go_to(r + 7);
        tx_req = 1'b0;
        expect_at(r + 8, K_TX, 0, "R3");
        go_to(r + 12);
        tx_req = 1'b1;
        expect_at(r + 14, K_TX, 0, "R2");
        expect_at(r + 15, K_TX, 1, "R2");
        go_to(r + 16);

        // T4: random backoff windows and persistent count
        do_reset(4, 1, 1'b0, 0, 1'b1, r);
        expect_at(r + 4, K_TX, 1, "R2");
        go_to(r + 5);
        for (int n = 1; n <= 5; n++) begin
            int c;
            int first_b;
            c = cyc;
            collision = 1'b1;
            @(negedge clk);
            collision = 1'b0;
            check("R4", "tx_ok after collision", int'(tx_ok), 0);
            check("R4", "coll_cnt after collision", int'(coll_cnt), n);
            first_b = r + 4 * (((c + 1 - r) / 4) + 1);
            wait_grant(600, e);
            if (e < 0) begin
                check("R6", "grant after backoff", 0, 1);
            end else begin
                check("R2", "rise on slot grid", (e - r) % 4, 0);
                check("R6", "backoff within window",
                      (e >= first_b && (e - first_b) / 4 <= window(n)) ? 1 : 0, 1);
            end
            @(negedge clk);
        end
        write_count(0);
        check("R5", "cleared count", int'(coll_cnt), 0);
        cnt_wr = 1'b1;
        cnt_wdata = 8'd9;
        collision = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
        collision = 1'b0;
        check("R5", "write beats collision", int'(coll_cnt), 9);

        // T2: zero slot length means 256 ticks; reset clears a nonzero count
        do_reset(0, 1, 1'b0, 0, 1'b1, r);
        expect_at(r + 1, K_CNT, 0, "R10");
        expect_at(r + 255, K_TX, 0, "R1");
        expect_at(r + 256, K_TX, 1, "R1");
        go_to(r + 257);

        // T3: slot counts bit ticks, not clocks
        do_reset(3, 3, 1'b0, 0, 1'b1, r);
        b1 = nth_boundary(r, 3, 1);
        expect_at(b1 - 1, K_TX, 0, "R1");
        expect_at(b1, K_TX, 1, "R1");
        go_to(b1 + 1);

        // T5: abort after the sixteenth collision, release by write
        do_reset(4, 1, 1'b0, 0, 1'b1, r);
        write_count(15);
        expect_at(r + 4, K_TX, 1, "R2");
        go_to(r + 6);
        collision = 1'b1;
        @(negedge clk);
        collision = 1'b0;
        check("R7", "coll_cnt at limit", int'(coll_cnt), 16);
        check("R7", "abort raised", int'(abort), 1);
        check("R7", "tx_ok at abort", int'(tx_ok), 0);
        expect_at(r + 11, K_TX, 0, "R7");
        expect_at(r + 27, K_TX, 0, "R7");
        expect_at(r + 47, K_TX, 0, "R7");
        expect_at(r + 47, K_ABORT, 1, "R7");
        go_to(r + 60);
        write_count(0);
        check("R7", "abort released", int'(abort), 0);
        wait_grant(2500, e);
        check("R7", "grant after release", (e >= 0) ? 1 : 0, 1);

        // T6: fixed slot cycle of 4, own slot 2, slot length 3
        do_reset(3, 1, 1'b1, 2, 1'b1, r);
        write_count(4);
        expect_at(r + 5, K_TX, 0, "R8");
        expect_at(r + 6, K_TX, 1, "R8");
        expect_at(r + 8, K_TX, 1, "R8");
        expect_at(r + 9, K_TX, 0, "R8");
        expect_at(r + 17, K_TX, 0, "R8");
        expect_at(r + 18, K_TX, 1, "R8");
        expect_at(r + 20, K_TX, 0, "R9");
        expect_at(r + 21, K_CNT, 4, "R8");
        expect_at(r + 29, K_TX, 0, "R9");
        expect_at(r + 30, K_TX, 1, "R9");
        go_to(r + 19);
        collision = 1'b1;
        @(negedge clk);
        collision = 1'b0;
        go_to(r + 32);

        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule